// File: doc/BRIEF.md
# Shared Forward/Inverse AES Column Mixer

This block applies either the forward AES column mix or its inverse to a 16-byte state. A mode input selects which one. The state is captured whole on a start pulse. The engine then walks through it one byte per clock. Each byte is folded into four column accumulators, which rotate after every byte. When a column is complete, its four results are written back in place.

One datapath serves both modes. The inverse matrix (0e 0b 0d 09, circulant) is the forward matrix (02 03 01 01, circulant) plus a circulant built from 0c and 08. So the forward path is just the inverse path with two doublings and their XOR steps skipped.

Latency is the same in both modes, and no step depends on data values. The block is meant to sit next to a round sequencer that supplies states and reads them back. S-box, key addition and round control live elsewhere.

Top module: `mixcol_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0.
- R2: A start_i sampled while busy_o is 0 loads state_i and raises busy_o. Exactly 16 clock edges later, busy_o falls and done_o is 1 for a single cycle. This latency is the same in both modes and for every data value.
- R3: With inv_i = 0, the result is the forward column mix. State byte k sits at state_i[8k+7:8k]. Column c is bytes 4c..4c+3, with row r being byte 4c+r. Output row r equals the XOR over k of coef[(k-r) mod 4] times input row k, using coef = {02, 03, 01, 01}. Products are taken in GF(2^8).
- R4: With inv_i = 1, the same rule applies with coef = {0e, 0b, 0d, 09}.
- R5: GF(2^8) doubling shifts left by one bit. When the bit shifted out is 1, the result is XORed with 0x1B. This holds for every byte value in every state position.
- R6: A start_i while busy_o is 1 is ignored. A change of inv_i during a run is also ignored: the mode is the value sampled with the accepted start.
- R7: After done_o, state_o keeps the result unchanged until the next accepted start, whatever state_i does.
- R8: A start_i in the same cycle as done_o is accepted, so runs can follow back to back.
- R9: Running the inverse mode on a forward-mode result returns the original state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transform; taken only when idle |
| inv_i | input | 1 | 0 = forward mix, 1 = inverse mix; sampled with start |
| state_i | input | 128 | State to transform; byte k at bits 8k+7:8k |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle pulse when state_o holds the result |
| state_o | output | 128 | Transformed state |

## Verification
Two functions can fall in the same cycle. The first is completion: done_o rises and busy_o falls. The second is acceptance of a new start. The bench provokes this overlap by raising start_i, with a fresh state and the opposite mode, on the very cycle it sees done_o. It then judges both results against arithmetic references: the first must be intact when done is observed, and the second must be a correct transform. A start raised mid-run, together with a mode flip, must leave the running transform untouched. A full sweep of all byte values in every position, in both modes, exercises the 0x1B reduction.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [COL_BYTES-1:0] col_t;

  localparam byte_t REDUCE = 8'h1B;

  function automatic byte_t xtime(byte_t b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? REDUCE : byte_t'(0));
  endfunction
endpackage

// File: rtl/mixcol_term.sv
// Per-byte contribution to the four accumulators; forward is a truncated inverse path.
module mixcol_term
  import mixcol_pkg::*;
(
  input  byte_t t_i,
  input  logic  inv_i,
  output col_t  add_o
);
  byte_t d1, d2, d3, tail;

  always_comb begin
    d1 = xtime(t_i);
    d2 = xtime(d1);
    d3 = xtime(d2);
    add_o    = '0;
    add_o[0] = t_i;
    add_o[1] = t_i;
    add_o[2] = t_i;
    if (inv_i) begin
      add_o[2] = add_o[2] ^ d1;
      add_o[3] = add_o[3] ^ d1;
      add_o[1] = add_o[1] ^ d2;
      add_o[3] = add_o[3] ^ d2;
      add_o[0] = add_o[0] ^ d3;
      add_o[1] = add_o[1] ^ d3;
      tail = d3;
    end else begin
      tail = d1;
    end
    add_o[2] = add_o[2] ^ tail;
    add_o[3] = add_o[3] ^ tail;
  end
endmodule

// File: rtl/mixcol_acc.sv
module mixcol_acc
  import mixcol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  col_t add_i,
  output col_t sum_o
);
  col_t acc_q, mixed;

  always_comb mixed = (first_i ? col_t'('0) : acc_q) ^ add_i;

  // rotate down: slot j takes slot j+1
  for (genvar j = 0; j < COL_BYTES; j++) begin : g_rot
    assign sum_o[j] = mixed[(j + 1) % COL_BYTES];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/mixcol_seq.sv
module mixcol_seq #(
  parameter int NUM_COLS = 4,
  localparam int STEPS  = NUM_COLS * mixcol_pkg::COL_BYTES,
  localparam int CNT_W  = $clog2(STEPS),
  localparam int ROW_W  = $clog2(mixcol_pkg::COL_BYTES),
  localparam int CIDX_W = CNT_W - ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              inv_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              inv_o,
  output logic [CIDX_W-1:0] col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              first_o,
  output logic              last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_end;

  assign load_o   = start_i & ~busy_o;
  assign row_o    = cnt_q[ROW_W-1:0];
  assign col_o    = cnt_q[CNT_W-1:ROW_W];
  assign first_o  = (row_o == '0);
  assign last_o   = (row_o == ROW_W'(mixcol_pkg::COL_BYTES - 1));
  assign step_end = (cnt_q == CNT_W'(STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      inv_o  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        inv_o  <= inv_i;
        cnt_q  <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (step_end) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          cnt_q  <= '0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R2
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));  // R2
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cnt_q == '0);  // R2
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(inv_o));  // R6
endmodule

// File: rtl/mixcol_engine.sv
module mixcol_engine #(
  parameter int NUM_COLS = 4,
  localparam int STATE_W = NUM_COLS * mixcol_pkg::COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               inv_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);
  import mixcol_pkg::*;

  localparam int STEPS  = NUM_COLS * COL_BYTES;
  localparam int CNT_W  = $clog2(STEPS);
  localparam int ROW_W  = $clog2(COL_BYTES);
  localparam int CIDX_W = CNT_W - ROW_W;

  logic               load, inv_run, first, last;
  logic [CIDX_W-1:0]  col;
  logic [ROW_W-1:0]   row;
  logic [STATE_W-1:0] data_q;
  byte_t              cur;
  col_t               add, sum;

  mixcol_seq #(.NUM_COLS(NUM_COLS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .inv_i   (inv_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .inv_o   (inv_run),
    .col_o   (col),
    .row_o   (row),
    .first_o (first),
    .last_o  (last)
  );

  always_comb cur = data_q[int'(col) * COL_W + int'(row) * BYTE_W +: BYTE_W];

  mixcol_term u_term (
    .t_i   (cur),
    .inv_i (inv_run),
    .add_o (add)
  );

  mixcol_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_o),
    .first_i (first),
    .add_i   (add),
    .sum_o   (sum)
  );

  // In-place write-back: accumulator j holds output row j+1 after the final rotate.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= state_i;
    end else if (busy_o && last) begin
      for (int j = 0; j < COL_BYTES; j++) begin
        data_q[int'(col) * COL_W + ((j + 1) % COL_BYTES) * BYTE_W +: BYTE_W] <= sum[j];
      end
    end
  end

  assign state_o = data_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(state_o));  // R7
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o);  // R1
endmodule

// File: tb/mixcol_engine_tb.sv
module mixcol_engine_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         inv_i = 1'b0;
  logic [127:0] state_i = '0;
  logic         busy_o, done_o;
  logic [127:0] state_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  mixcol_engine u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .inv_i   (inv_i),
    .state_i (state_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic [7:0] xt(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ a;
      a = xt(a);
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_mix(logic [127:0] s, bit inv);
    logic [7:0]   fc [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
    logic [7:0]   ic [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    logic [127:0] o = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 8'h00;
        for (int k = 0; k < 4; k++) begin
          acc = acc ^ gmul(inv ? ic[(k - r + 4) % 4] : fc[(k - r + 4) % 4],
                           s[c*32 + k*8 +: 8]);
        end
        o[c*32 + r*8 +: 8] = acc;
      end
    end
    return o;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start a run at a negedge; return result and posedge count until done.
  task automatic run(input logic [127:0] s, input bit inv,
                     output logic [127:0] res, output int lat);
    start_i = 1'b1; state_i = s; inv_i = inv;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    res = state_o;
  endtask

  initial begin
    logic [127:0] res, res2, s, ka_in, ka_out;
    int lat;

    ka_in  = {32'hc6c6c6c6, 32'h01010101, 32'h5c220af2, 32'h455313db};
    ka_out = {32'hc6c6c6c6, 32'h01010101, 32'h9d58dc9f, 32'hbca14d8e};

    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset idle",
          {126'b0, busy_o, done_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 after release",
          {126'b0, busy_o, done_o}, '0);

    // known answers
    run(ka_in, 1'b0, res, lat);
    check(res == ka_out, "R3 forward known answer", res, ka_out);
    check(lat == 17, "R2 forward latency", 128'(lat), 128'd17);
    @(negedge clk_i);
    check(done_o == 1'b0, "R2 done single cycle", {127'b0, done_o}, '0);
    run(ka_out, 1'b1, res, lat);
    check(res == ka_in, "R4 inverse known answer", res, ka_in);
    check(lat == 17, "R2 inverse latency", 128'(lat), 128'd17);

    // sweep every byte value through every position, both modes (R5)
    for (int v = 0; v < 256; v++) begin
      for (int k = 0; k < 16; k++) s[k*8 +: 8] = 8'((v + 37 * k) & 255);
      run(s, 1'b0, res, lat);
      check(res == ref_mix(s, 1'b0), "R5 R3 forward sweep", res, ref_mix(s, 1'b0));
      run(s, 1'b1, res, lat);
      check(res == ref_mix(s, 1'b1), "R5 R4 inverse sweep", res, ref_mix(s, 1'b1));
      check(lat == 17, "R2 sweep latency", 128'(lat), 128'd17);
    end

    // random round trips
    for (int n = 0; n < 64; n++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      run(s, 1'b0, res, lat);
      run(res, 1'b1, res2, lat);
      check(res2 == s, "R9 round trip", res2, s);
    end

    // start and mode change during a run are ignored
    s = {$urandom, $urandom, $urandom, $urandom};
    start_i = 1'b1; state_i = s; inv_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    start_i = 1'b1; state_i = ~s; inv_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && cycles < 140000) @(negedge clk_i);
    check(state_o == ref_mix(s, 1'b0), "R6 mid-run start and mode ignored",
          state_o, ref_mix(s, 1'b0));

    // output holds after done
    res = state_o;
    state_i = {$urandom, $urandom, $urandom, $urandom};
    inv_i = 1'b1;
    repeat (6) @(negedge clk_i);
    check(state_o == res && busy_o == 1'b0, "R7 result held", state_o, res);

    // back-to-back: start raised in the done cycle
    s = {$urandom, $urandom, $urandom, $urandom};
    run(s, 1'b0, res, lat);
    check(done_o == 1'b1 && busy_o == 1'b0, "R8 done with busy low",
          {126'b0, done_o, busy_o}, {126'b0, 2'b10});
    check(res == ref_mix(s, 1'b0), "R8 first result intact", res, ref_mix(s, 1'b0));
    run(res, 1'b1, res2, lat);
    check(res2 == s, "R8 back-to-back second result", res2, s);
    check(lat == 17, "R8 back-to-back latency", 128'(lat), 128'd17);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule